// File: doc/BRIEF.md
# Carry-Save Tree Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits, with no clock and no internal state. Every bit pairing of the two operands forms one partial-product bit. These bits are stacked by binary weight into columns. Each column is then reduced in parallel by layers of 3:2 counters and 2:2 counters. A carry never travels along a layer: a counter in column i leaves its sum in column i and passes its carry to column i+1 of the next layer.

Layers are applied until no column holds more than two bits. The two rows that remain go to a carry-lookahead adder. That adder is built from 4-bit groups, and a second lookahead level combines the group generate and propagate terms. The number of layers is derived from `WIDTH` and grows with its logarithm. The default of 32 needs eight layers and a width of 4 needs two. The product is exactly twice the operand width, so no operand pair can overflow it.

There is no state machine. The block is a single combinational path from the operand ports to the product port, and it has no reset. An instantiating design registers the inputs and outputs as its own timing requires.

Top module: `tree_multiplier`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals `opa * opb`, taken over the full `2*WIDTH` bits.
- R2: Product bit 0 always equals the AND of operand bit 0 of `opa` and operand bit 0 of `opb`.
- R3: If either operand is zero, every bit of `prod` is zero.
- R4: If one operand equals 1, `prod` equals the other operand, zero-extended to `2*WIDTH` bits.
- R5: If both operands are all ones, `prod` equals 2^(2W) - 2^(W+1) + 1. This is the largest possible product, and it is represented without loss.
- R6: The block holds no state. A change on the operands appears on `prod` without any clock edge.
- R7: Swapping the two operands does not change `prod`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | Unsigned multiplicand |
| opb | input | WIDTH | Unsigned multiplier |
| prod | output | 2*WIDTH | Unsigned product of the two operands |

## Verification
The bench builds two copies of the block.

The first copy uses `WIDTH = 4`. At that width all 256 operand pairs can be checked, so every path through the two reduction layers and the lookahead adder is exercised. This includes the only settings that drive carries into the top column.

The second copy uses the default `WIDTH = 32`. It takes a table of corner operands (zero, one, all ones, single high bits and alternating patterns), then 10,000 random pairs, and then operand swaps. This reaches the deep eight-layer tree and the carry chains that cross lookahead groups.

// File: rtl/tree_mult_pkg.sv
package tree_mult_pkg;

    // Reduction layers needed to bring a column of height h down to two rows.
    // The permitted heights follow 2, 3, 4, 6, 9, 13, ...
    function automatic int layers_for(input int h);
        int d;
        int n;
        d = 2;
        n = 0;
        while (d < h) begin
            d = (d * 3) / 2;
            n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/pp_array.sv
module pp_array #(
    parameter int W = 32
) (
    input  logic [W-1:0]        mcand,
    input  logic [W-1:0]        mplier,
    output logic [W-1:0][W-1:0] pbits    // pbits[i][j] = mcand[j] & mplier[i], weight i+j
);
    for (genvar i = 0; i < W; i++) begin : g_row
        assign pbits[i] = mcand & {W{mplier[i]}};
    end
endmodule

// File: rtl/csa_tree.sv
module csa_tree #(
    parameter int W = 32
) (
    input  logic [W-1:0][W-1:0] pbits,
    output logic [2*W-1:0]      row0,
    output logic [2*W-1:0]      row1
);
    import tree_mult_pkg::*;

    localparam int COLS   = 2 * W;
    localparam int HMAX   = W;
    localparam int LAYERS = layers_for(W) + 1;   // one spare layer, skipped once done

    logic [HMAX-1:0] cur [COLS];
    logic [HMAX-1:0] nxt [COLS];
    int              ch  [COLS];
    int              nh  [COLS];
    int              tallest;
    logic            x0, x1, x2;

    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            cur[c] = '0;
            nxt[c] = '0;
            ch[c]  = 0;
            nh[c]  = 0;
        end
        x0 = 1'b0;
        x1 = 1'b0;
        x2 = 1'b0;

        // Stack the partial-product bits into columns by weight.
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                cur[i + j][ch[i + j]] = pbits[i][j];
                ch[i + j]++;
            end
        end

        for (int lay = 0; lay < LAYERS; lay++) begin
            tallest = 0;
            for (int c = 0; c < COLS; c++) begin
                if (ch[c] > tallest) tallest = ch[c];
            end
            if (tallest > 2) begin
                for (int c = 0; c < COLS; c++) begin
                    nxt[c] = '0;
                    nh[c]  = 0;
                end
                for (int c = 0; c < COLS; c++) begin
                    for (int k = 0; k < HMAX; k += 3) begin
                        if (ch[c] - k >= 3) begin
                            // 3:2 counter: the sum stays in this column, the carry moves up one
                            x0 = cur[c][k];
                            x1 = cur[c][k + 1];
                            x2 = cur[c][k + 2];
                            if (nh[c] < HMAX) nxt[c][nh[c]] = x0 ^ x1 ^ x2;
                            nh[c]++;
                            if (c + 1 < COLS) begin
                                if (nh[c + 1] < HMAX)
                                    nxt[c + 1][nh[c + 1]] = (x0 & x1) | (x2 & (x0 ^ x1));
                                nh[c + 1]++;
                            end
                        end else if (ch[c] - k == 2) begin
                            // 2:2 counter for two leftover bits
                            x0 = cur[c][k];
                            x1 = cur[c][k + 1];
                            if (nh[c] < HMAX) nxt[c][nh[c]] = x0 ^ x1;
                            nh[c]++;
                            if (c + 1 < COLS) begin
                                if (nh[c + 1] < HMAX) nxt[c + 1][nh[c + 1]] = x0 & x1;
                                nh[c + 1]++;
                            end
                        end else if (ch[c] - k == 1) begin
                            // a single leftover bit passes straight through
                            if (nh[c] < HMAX) nxt[c][nh[c]] = cur[c][k];
                            nh[c]++;
                        end
                    end
                end
                for (int c = 0; c < COLS; c++) begin
                    cur[c] = nxt[c];
                    ch[c]  = nh[c];
                end
            end
        end

        for (int c = 0; c < COLS; c++) begin
            row0[c] = (ch[c] >= 1) ? cur[c][0] : 1'b0;
            row1[c] = (ch[c] >= 2) ? cur[c][1] : 1'b0;
        end
    end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] xa,
    input  logic [AW-1:0] xb,
    output logic [AW-1:0] sum
);
    localparam int GRP = 4;
    localparam int NG  = (AW + GRP - 1) / GRP;
    localparam int PW  = NG * GRP;

    logic [PW-1:0] ga, gb, gen, prp, cin;
    logic [NG-1:0] grp_g, grp_p;
    logic [NG:0]   grp_c;
    logic          term;

    always_comb begin
        ga  = PW'(xa);
        gb  = PW'(xb);
        gen = ga & gb;
        prp = ga ^ gb;

        // First level: generate and propagate terms for each 4-bit group
        for (int k = 0; k < NG; k++) begin
            grp_g[k] = 1'b0;
            grp_p[k] = 1'b1;
            for (int i = 0; i < GRP; i++) begin
                grp_g[k] = gen[k*GRP + i] | (prp[k*GRP + i] & grp_g[k]);
                grp_p[k] = grp_p[k] & prp[k*GRP + i];
            end
        end

        // Second level: the carry into each group comes from a flat sum of products
        grp_c[0] = 1'b0;
        for (int k = 0; k < NG; k++) begin
            grp_c[k + 1] = 1'b0;
            for (int j = 0; j <= k; j++) begin
                term = grp_g[j];
                for (int m = j + 1; m <= k; m++) term = term & grp_p[m];
                grp_c[k + 1] = grp_c[k + 1] | term;
            end
        end

        // Carries inside each group, taken from the group's incoming carry
        for (int k = 0; k < NG; k++) begin
            cin[k*GRP] = grp_c[k];
            for (int i = 1; i < GRP; i++)
                cin[k*GRP + i] = gen[k*GRP + i - 1] | (prp[k*GRP + i - 1] & cin[k*GRP + i - 1]);
        end

        sum = AW'(prp ^ cin);
    end

    always_comb begin
        p_cla_sum_r1: assert (sum == AW'(xa + xb))
            else $error("lookahead adder result differs from the sum of its two rows");
    end
endmodule

// File: rtl/tree_multiplier.sv
module tree_multiplier #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   opa,
    input  logic [WIDTH-1:0]   opb,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0][WIDTH-1:0] pbits;
    logic [PW-1:0]               row0;
    logic [PW-1:0]               row1;

    pp_array #(.W(WIDTH)) u_pp (
        .mcand  (opa),
        .mplier (opb),
        .pbits  (pbits)
    );

    csa_tree #(.W(WIDTH)) u_tree (
        .pbits (pbits),
        .row0  (row0),
        .row1  (row1)
    );

    cla_adder #(.AW(PW)) u_cla (
        .xa  (row0),
        .xb  (row1),
        .sum (prod)
    );

    always_comb begin
        p_full_product_r1: assert (prod == (PW'(opa) * PW'(opb)))
            else $error("product differs from the arithmetic product");
        p_lsb_direct_r2: assert (prod[0] == (opa[0] & opb[0]))
            else $error("product bit 0 is not the AND of the operand LSBs");
        p_zero_operand_r3: assert (!(opa == '0 || opb == '0) || prod == '0)
            else $error("zero operand gave a nonzero product");
        p_unit_operand_r4: assert (opb != WIDTH'(1) || prod == PW'(opa))
            else $error("multiplying by one changed the operand");
    end
endmodule

// File: tb/tree_multiplier_tb.sv
module tree_multiplier_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;   // 100 MHz

    logic [31:0] a32, b32;
    logic [63:0] p32;
    logic [3:0]  a4, b4;
    logic [7:0]  p4;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    tree_multiplier #(.WIDTH(32)) u_dut (
        .opa  (a32),
        .opb  (b32),
        .prod (p32)
    );

    tree_multiplier #(.WIDTH(4)) u_dut_w4 (
        .opa  (a4),
        .opb  (b4),
        .prod (p4)
    );

    // Each entry holds operand a, operand b and the expected product.
    localparam int NV = 10;
    localparam logic [127:0] VECS [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 64'h0},                     // R3
        {32'h0000_0000, 32'hFFFF_FFFF, 64'h0},                     // R3
        {32'hDEAD_BEEF, 32'h0000_0000, 64'h0},                     // R3
        {32'h0000_0001, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_FFFF},   // R4
        {32'h1234_5678, 32'h0000_0001, 64'h0000_0000_1234_5678},   // R4
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFE_0000_0001},   // R5
        {32'h8000_0000, 32'h8000_0000, 64'h4000_0000_0000_0000},   // R1
        {32'h0001_0000, 32'h0001_0000, 64'h0000_0001_0000_0000},   // R1
        {32'hFFFF_FFFF, 32'h0000_0002, 64'h0000_0001_FFFF_FFFE},   // R1
        {32'h0000_0003, 32'h0000_0003, 64'h0000_0000_0000_0009}    // R2
    };
    localparam string VTAG [NV] = '{"R3", "R3", "R3", "R4", "R4", "R5", "R1", "R1", "R1", "R2"};

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        a32 = '0; b32 = '0; a4 = '0; b4 = '0;
        @(negedge clk);
        // idle state: zero operands
        check(p32, 64'h0, "R3");
        check(64'(p4), 64'h0, "R3");

        // table walk
        for (int v = 0; v < NV; v++) begin
            @(posedge clk);
            a32 <= VECS[v][127:96];
            b32 <= VECS[v][95:64];
            @(negedge clk);
            check(p32, VECS[v][63:0], VTAG[v]);
        end

        // R1 R2 R3 R4: exhaustive at width 4
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                @(posedge clk);
                a4 <= 4'(i);
                b4 <= 4'(j);
                @(negedge clk);
                check(64'(p4), 64'(i * j), "R1");
                check(64'(p4[0]), 64'(i & j & 1), "R2");
            end
        end
        // R5 at width 4: 15*15 = 225
        @(posedge clk); a4 <= 4'hF; b4 <= 4'hF;
        @(negedge clk); check(64'(p4), 64'd225, "R5");

        // R1: alternating patterns
        @(posedge clk); a32 <= 32'hAAAA_AAAA; b32 <= 32'h5555_5555;
        @(negedge clk); check(p32, 64'(a32) * 64'(b32), "R1");
        @(posedge clk); a32 <= 32'hAAAA_AAAA; b32 <= 32'hAAAA_AAAA;
        @(negedge clk); check(p32, 64'(a32) * 64'(b32), "R1");
        @(posedge clk); a32 <= 32'h5555_5555; b32 <= 32'h5555_5555;
        @(negedge clk); check(p32, 64'(a32) * 64'(b32), "R1");

        // R1: random pairs
        for (int r = 0; r < 10000; r++) begin
            @(posedge clk);
            a32 <= $urandom();
            b32 <= $urandom();
            @(negedge clk);
            check(p32, 64'(a32) * 64'(b32), "R1");
        end

        // R7: swapping operands leaves the product unchanged
        for (int r = 0; r < 20; r++) begin
            logic [31:0] x, y;
            logic [63:0] first;
            x = $urandom();
            y = $urandom();
            @(posedge clk); a32 <= x; b32 <= y;
            @(negedge clk); first = p32;
            @(posedge clk); a32 <= y; b32 <= x;
            @(negedge clk); check(p32, first, "R7");
        end

        // R6: result follows operands between clock edges
        @(negedge clk);
        a32 = 32'd1000; b32 = 32'd1000;
        #1 check(p32, 64'd1000000, "R6");
        a32 = 32'd7;
        #1 check(p32, 64'd7000, "R6");

        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule